// File: doc/BRIEF.md
# Two-Port Arbiter for a Slow Word Memory

This block lets two requesters, typically two data caches, share one data memory that is slow and can serve only one access at a time. Each requester has its own address, write word, read/write select and request strobe, and gets back a read word and a completion flag. The arbiter picks one requester and passes its access to the memory. It keeps that choice fixed until the memory reports completion, and it returns the completion and the read word only to the side that was chosen.

The memory is a behavioural model with a fixed latency, placed inside the block so that the arbiter can be tested alone. It takes a 16-bit word address and one 16-bit word per line, so the address space is 65,536 lines. To keep elaboration small, the model stores only 2**STORE_AW words and selects them with the low address bits. A requester raises its strobe and holds it, with address and data stable, until it sees its completion flag. It drops the strobe in the cycle after that.

A requester that finds the memory busy waits for the whole access in progress plus one idle cycle, and then waits its own full latency.

Top module: `dual_mem_arbiter`

## Requirements
- R1: After reset, both completion flags are 0, both read words are 0, and no access is in progress.
- R2: With the memory idle, a strobe that is present at a rising edge is accepted at that edge. The requester's completion flag is then high for exactly one cycle, first visible after the LAT-th rising edge counted from acceptance (LAT defaults to 4).
- R3: A read returns the word most recently written to the same address, by either requester.
- R4: While an access is in progress, no other strobe is accepted. A requester that is held off in this way sees its completion 2*LAT+1 rising edges after it raised its strobe.
- R5: When both strobes are present in the same idle cycle, the round-robin pointer chooses the winner. After reset the pointer favours requester 0.
- R6: Every grant moves the pointer to the requester that was not granted. After a lone grant to requester 0, the next simultaneous request is won by requester 1.
- R7: The completion flag and the read word go only to the granted requester. The other requester's flag stays 0 and its read word stays 0, and the two flags are never high together.
- R8: Address, data and select are captured when the access is accepted. Changes made by the requester during the access have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_strobe | input | 2 | Access request, bit i for requester i, held until completion |
| req_rnotw | input | 2 | 1 = read, 0 = write, per requester |
| req_addr | input | 2 x ADDR_W | Word address per requester |
| req_wdata | input | 2 x DATA_W | Write word per requester |
| rsp_done | output | 2 | One-cycle completion pulse per requester |
| rsp_rdata | output | 2 x DATA_W | Read word, valid with the completion pulse, otherwise 0 |

## Verification
A grant lock that does not clear would show up right away: the next strobe from either side would get no completion at all. A lock that clears too early would let a held-off requester complete after fewer than 2*LAT+1 edges. A wrong owner register would route the completion pulse or the read word to the idle side during the same cycle as the pulse. A pointer that does not flip would change which side wins the second simultaneous request, and this would show within about LAT cycles as a swapped completion order. A latency counter that is off by one would move every completion pulse by one edge.

// File: rtl/dual_mem_arbiter_pkg.sv
// Shared constants for the two-port slow memory arbiter.
package dual_mem_arbiter_pkg;
    localparam int NUM_REQ = 2;
    typedef logic req_id_t;
endpackage

// File: rtl/arb_rr_pick.sv
// Chooses which requester goes to the memory this cycle.
// Assumes: exactly two requesters; rr_ptr names the side favoured in a tie.
// A grant is offered only while no access is locked in.
module arb_rr_pick
    import dual_mem_arbiter_pkg::*;
(
    input  logic [NUM_REQ-1:0] req,
    input  req_id_t            rr_ptr,
    input  logic               locked,
    output logic               grant_valid,
    output req_id_t            grant_id
);
    // Tie broken by the pointer, otherwise the lone requester wins.
    always_comb begin
        grant_id = 1'b0;
        if (req[0] && req[1]) begin
            grant_id = rr_ptr;
        end else if (req[1]) begin
            grant_id = 1'b1;
        end
        grant_valid = !locked && (req != '0);
    end
endmodule

// File: rtl/arb_grant_lock.sv
// Holds the grant from acceptance until the memory's completion pulse,
// and keeps the round-robin pointer.
// Assumes: the memory accepts exactly when a grant is offered (it is idle
// whenever the lock is clear).
module arb_grant_lock
    import dual_mem_arbiter_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    grant_valid,
    input  req_id_t grant_id,
    input  logic    mem_done,
    output logic    locked,
    output req_id_t owner,
    output req_id_t rr_ptr
);
    // Lock, owner and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            owner  <= 1'b0;
            rr_ptr <= 1'b0;
        end else if (grant_valid) begin
            locked <= 1'b1;
            owner  <= grant_id;
            rr_ptr <= ~grant_id;
        end else if (locked && mem_done) begin
            locked <= 1'b0;
        end
    end
endmodule

// File: rtl/mem_slow_store.sv
// Behavioural single-port word memory with a fixed access latency.
// Accepts a strobe only when idle, latches the request, and raises done for
// one cycle LAT edges after acceptance; writes land on that last edge.
// Assumes LAT >= 1. Only 2**STORE_AW words are kept, indexed by low address bits.
module mem_slow_store #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int LAT      = 4,
    parameter int STORE_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              rnotw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam int DEPTH = 1 << STORE_AW;

    logic [DATA_W-1:0]   cells [DEPTH];
    logic                busy_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [STORE_AW-1:0] idx_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                rnotw_q;

    assign done  = busy_q && (cnt_q == '0);
    assign rdata = (done && rnotw_q) ? cells[idx_q] : '0;

    // Acceptance, request capture and latency countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            idx_q   <= '0;
            wdata_q <= '0;
            rnotw_q <= 1'b1;
        end else if (!busy_q && strobe) begin
            busy_q  <= 1'b1;
            cnt_q   <= CNT_W'(LAT - 1);
            idx_q   <= addr[STORE_AW-1:0];
            wdata_q <= wdata;
            rnotw_q <= rnotw;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    // Write commit on the completing edge.
    always_ff @(posedge clk) begin
        if (done && !rnotw_q) begin
            cells[idx_q] <= wdata_q;
        end
    end
endmodule

// File: rtl/dual_mem_arbiter.sv
// Top: two requesters share one slow memory through a locked round-robin grant.
// Assumes each requester holds its strobe and request fields until it sees its
// own completion pulse. The response goes to the owner of the grant only.
module dual_mem_arbiter
    import dual_mem_arbiter_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int LAT      = 4,
    parameter int STORE_AW = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_REQ-1:0]             req_strobe,
    input  logic [NUM_REQ-1:0]             req_rnotw,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0] req_addr,
    input  logic [NUM_REQ-1:0][DATA_W-1:0] req_wdata,
    output logic [NUM_REQ-1:0]             rsp_done,
    output logic [NUM_REQ-1:0][DATA_W-1:0] rsp_rdata
);
    logic              grant_valid;
    req_id_t           grant_id;
    logic              locked;
    req_id_t           owner;
    req_id_t           rr_ptr;
    req_id_t           sel;
    logic              mem_strobe;
    logic              mem_done;
    logic [DATA_W-1:0] mem_rdata;

    arb_rr_pick u_pick (
        .req         (req_strobe),
        .rr_ptr      (rr_ptr),
        .locked      (locked),
        .grant_valid (grant_valid),
        .grant_id    (grant_id)
    );

    arb_grant_lock u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .grant_id    (grant_id),
        .mem_done    (mem_done),
        .locked      (locked),
        .owner       (owner),
        .rr_ptr      (rr_ptr)
    );

    // Request mux: the new winner when idle, the owner while locked.
    always_comb begin
        sel        = locked ? owner : grant_id;
        mem_strobe = grant_valid;
    end

    mem_slow_store #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LAT      (LAT),
        .STORE_AW (STORE_AW)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (mem_strobe),
        .rnotw  (req_rnotw[sel]),
        .addr   (req_addr[sel]),
        .wdata  (req_wdata[sel]),
        .done   (mem_done),
        .rdata  (mem_rdata)
    );

    // Per-requester response routing.
    for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_route
        assign rsp_done[gi]  = mem_done && locked && (owner == req_id_t'(gi));
        assign rsp_rdata[gi] = rsp_done[gi] ? mem_rdata : '0;
    end
endmodule

// File: rtl/dual_mem_arbiter_chk.sv
// Property checker for dual_mem_arbiter, attached by bind.
// Tracks the age of the current access with its own counter.
module dual_mem_arbiter_chk #(
    parameter int LAT = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rsp_done,
    input logic       locked,
    input logic       owner,
    input logic       mem_done,
    input logic       mem_strobe
);
    logic [15:0] age_q;

    // Counts edges since the current access was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (mem_strobe) begin
            age_q <= '0;
        end else if (locked && age_q != 16'hFFFF) begin
            age_q <= age_q + 1'b1;
        end
    end

    p_one_side_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_done));

    p_done_in_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |-> locked);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |-> (age_q == 16'(LAT - 1)));

    p_no_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !mem_strobe);

    p_owner_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !mem_done) |=> (locked && $stable(owner)));

    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && mem_done) |=> !locked);
endmodule

bind dual_mem_arbiter dual_mem_arbiter_chk #(.LAT(LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_done   (rsp_done),
    .locked     (locked),
    .owner      (owner),
    .mem_done   (mem_done),
    .mem_strobe (mem_strobe)
);

// File: tb/dual_mem_arbiter_test.sv
module dual_mem_arbiter_test;
    localparam int LAT = 4;

    typedef struct packed {
        logic        port;
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
    } vec_t;

    // Writes store data; reads expect data.
    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b1, 16'h0010, 16'hA5A5},
        '{1'b1, 1'b1, 16'h0020, 16'h1234},
        '{1'b1, 1'b0, 16'h0010, 16'hA5A5},
        '{1'b0, 1'b0, 16'h0020, 16'h1234},
        '{1'b0, 1'b1, 16'h03FF, 16'hFFFF},
        '{1'b1, 1'b0, 16'h03FF, 16'hFFFF},
        '{1'b1, 1'b1, 16'h0000, 16'h0001},
        '{1'b0, 1'b0, 16'h0000, 16'h0001}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       req_strobe = '0;
    logic [1:0]       req_rnotw = '1;
    logic [1:0][15:0] req_addr = '0;
    logic [1:0][15:0] req_wdata = '0;
    logic [1:0]       rsp_done;
    logic [1:0][15:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dual_mem_arbiter #(.LAT(LAT)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_strobe (req_strobe),
        .req_rnotw  (req_rnotw),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_strobe = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 done flags after reset", rsp_done, 0);
        check("R1 read words after reset", rsp_rdata, 0);
    endtask

    // Single access on one port; checks latency, data and the quiet other side.
    task automatic one_access(input logic p, input logic wr, input logic [15:0] a,
                              input logic [15:0] d, input logic swap_addr);
        int edges = 0;
        bit quiet = 1'b1;
        @(negedge clk);
        req_addr[p]   = a;
        req_wdata[p]  = d;
        req_rnotw[p]  = ~wr;
        req_strobe[p] = 1'b1;
        while (edges < 50) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (swap_addr && edges == 1) req_addr[p] = a ^ 16'h0030;
            if (rsp_done[!p] || rsp_rdata[!p] != 0) quiet = 1'b0;
            if (rsp_done[p]) break;
        end
        check("R2 latency in edges", edges, LAT);
        check("R7 other side quiet", quiet, 1);
        if (!wr) check(swap_addr ? "R8 captured address" : "R3 read data", rsp_rdata[p], d);
        req_strobe[p] = 1'b0;
        @(negedge clk);
        check("R2 pulse lasts one cycle", rsp_done[p], 0);
    endtask

    // Both ports read at once; checks winner and both latencies.
    task automatic contend(input logic first, input string tag);
        int e0 = 0;
        int e1 = 0;
        int edges = 0;
        bit both = 1'b0;
        @(negedge clk);
        req_addr[0] = 16'h0010; req_rnotw[0] = 1'b1;
        req_addr[1] = 16'h0020; req_rnotw[1] = 1'b1;
        req_strobe = 2'b11;
        while ((e0 == 0 || e1 == 0) && edges < 60) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (rsp_done == 2'b11) both = 1'b1;
            if (rsp_done[0] && e0 == 0) begin
                e0 = edges;
                check("R3 port0 read under contention", rsp_rdata[0], 16'hA5A5);
                req_strobe[0] = 1'b0;
            end
            if (rsp_done[1] && e1 == 0) begin
                e1 = edges;
                check("R3 port1 read under contention", rsp_rdata[1], 16'h1234);
                req_strobe[1] = 1'b0;
            end
        end
        check({tag, " winner latency"}, first ? e1 : e0, LAT);
        check("R4 held-off latency", first ? e0 : e1, 2 * LAT + 1);
        check("R7 flags never together", both, 0);
        @(negedge clk);
    endtask

    // Watchdog: a hang counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        foreach (VEC[i]) begin
            one_access(VEC[i].port, VEC[i].wr, VEC[i].addr, VEC[i].data, 1'b0);
        end
        // R5: pointer favours port 0 after reset
        do_reset();
        contend(1'b0, "R5");
        // R6: lone grant to port 0 moves the pointer to port 1
        one_access(1'b0, 1'b0, 16'h0010, 16'hA5A5, 1'b0);
        contend(1'b1, "R6");
        // R8: address changed mid-access does not redirect the read
        one_access(1'b0, 1'b0, 16'h0020, 16'h1234, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule